// File: doc/BRIEF.md
# SPI Packet Sequencer with Pause

This block is the control state machine at the heart of an SPI master. Software programs a packet length in bytes and a packet repeat count, then issues an activate command. The sequencer asserts chip select and enables the timing generator and byte shifter. It counts each byte the shifter reports until length times repeats bytes have moved. The counts are captured when the transfer starts, so software may prepare the next transfer's values while the current one runs.

On completion the sequencer does one of two things. Normally it releases chip select, latches a finish flag and returns to idle. When the pause mode input is high, it keeps chip select asserted, latches a pause flag and waits in a paused state. A resume command then starts the next transfer under the same chip select. A software reset command returns the block to idle from any state. Two enables combine the latched flags into one interrupt line. A status read strobe clears the flags.

Top module: `spi_pkt_seq`

## Requirements
- R1: While rst_n is low at a clock edge, the block enters idle with cs_active=0, shift_en=0, paused=0, byte_idx=0, loop_idx=0, status=2'b00 and irq=0.
- R2: A cmd_act pulse in idle starts a transfer. From the next cycle, cs_active=1, shift_en=1, byte_idx=0 and loop_idx=0. pkt_len_m1 and pkt_loop_m1 are captured at that edge, and later changes to them do not affect the running transfer.
- R3: pkt_len_m1 (10 bits) holds bytes per packet minus one, and pkt_loop_m1 (8 bits) holds repeats minus one. The transfer completes on the byte_done pulse numbered (pkt_len_m1+1)*(pkt_loop_m1+1). After k earlier pulses, byte_idx = k mod (pkt_len_m1+1) and loop_idx = k div (pkt_len_m1+1).
- R4: If pause_en is low at completion, the next cycle shows idle: cs_active=0 and shift_en=0. The finish flag status[0] is set.
- R5: If pause_en is high at completion, the next cycle shows paused=1, cs_active=1 and shift_en=0. The pause flag status[1] is set.
- R6: A cmd_resume pulse while paused starts a new transfer, with values captured as in R2 and chip select kept asserted. cmd_resume has no effect in idle. cmd_act has no effect while running or paused.
- R7: A cmd_rst pulse in any state returns the block to idle on the next cycle, with chip select released, counters zero and both flags clear. It takes priority over every other command and event in the same cycle.
- R8: irq = (status[0] & fin_ie) | (status[1] & pause_ie).
- R9: A status_rd pulse clears both flags on the next cycle. A completion in the same cycle as a read still sets its flag.
- R10: byte_done pulses outside the running state change neither byte_idx nor loop_idx. After completion, the counters hold their final values, pkt_len_m1 and pkt_loop_m1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_act | input | 1 | Activate pulse, starts a transfer from idle |
| cmd_resume | input | 1 | Resume pulse, starts the next transfer from paused |
| cmd_rst | input | 1 | Software reset pulse |
| pause_en | input | 1 | Pause mode: hold chip select at completion |
| fin_ie | input | 1 | Finish interrupt enable |
| pause_ie | input | 1 | Pause interrupt enable |
| pkt_len_m1 | input | 10 | Bytes per packet minus one |
| pkt_loop_m1 | input | 8 | Packet repeats minus one |
| byte_done | input | 1 | Byte completed by the shifter |
| status_rd | input | 1 | Status read strobe, clears flags |
| cs_active | output | 1 | Chip select asserted (logical, active high) |
| shift_en | output | 1 | Enable for timing generator and shifter |
| paused | output | 1 | Block is in the paused state |
| byte_idx | output | 10 | Byte position within the current packet |
| loop_idx | output | 8 | Current packet repeat number |
| status | output | 2 | Flags: bit 0 finish, bit 1 pause |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume the command inputs are single-cycle pulses. They also assume byte_done pulses arrive one per byte and never in the cycle that starts a transfer, since the shifter is not yet enabled then. The bench drives every input at the falling edge as a one-cycle pulse, with random idle gaps between bytes. Commands that should be ignored are sent in isolation, so that the flags and counters they could have touched can be read back at the ports.

// File: rtl/spi_seq_pkg.sv
// Shared types of the SPI packet sequencer.
// Assumes: nothing beyond a 2-bit state encoding.
package spi_seq_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_RUN   = 2'd1,
        SEQ_PAUSE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/spi_seq_count.sv
// Byte and packet-repeat counter of the sequencer.
// It captures the length and repeat fields on start and advances on step.
// It holds at the final byte so that its values remain readable afterwards.
// Assumes: start and step are never high together; clear has priority.
module spi_seq_count #(
    parameter int LEN_W  = 10,
    parameter int LOOP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              start,
    input  logic              step,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic [LOOP_W-1:0] loop_m1,
    output logic [LEN_W-1:0]  byte_idx,
    output logic [LOOP_W-1:0] loop_idx,
    output logic              last
);
    logic [LEN_W-1:0]  len_lat;
    logic [LOOP_W-1:0] loop_lat;

    // Final byte of the final repeat.
    assign last = (byte_idx == len_lat) && (loop_idx == loop_lat);

    // Capture the fields on start; wrap the byte count into the repeat count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            byte_idx <= '0;
            loop_idx <= '0;
            len_lat  <= '0;
            loop_lat <= '0;
        end else if (start) begin
            byte_idx <= '0;
            loop_idx <= '0;
            len_lat  <= len_m1;
            loop_lat <= loop_m1;
        end else if (step && !last) begin
            if (byte_idx == len_lat) begin
                byte_idx <= '0;
                loop_idx <= loop_idx + 1'b1;
            end else begin
                byte_idx <= byte_idx + 1'b1;
            end
        end
    end

    // R3: the byte position never passes the captured packet length.
    p_byte_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_idx <= len_lat);

    // R10: with no start, step or clear, the counters do not move.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !start && !clear) |=> ($stable(byte_idx) && $stable(loop_idx)));
endmodule

// File: rtl/spi_seq_flags.sv
// Latched finish and pause flags and the combined interrupt.
// Priority order: clear, then set, then the read strobe.
// Assumes: set inputs are single-cycle pulses from the sequencer.
module spi_seq_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       set_fin,
    input  logic       set_pause,
    input  logic       rd,
    input  logic       fin_ie,
    input  logic       pause_ie,
    output logic [1:0] flags,
    output logic       irq
);
    // Flag update: sets win over a simultaneous read.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            flags <= 2'b00;
        end else begin
            flags[0] <= set_fin   | (flags[0] & ~rd);
            flags[1] <= set_pause | (flags[1] & ~rd);
        end
    end

    // Gate the flags with their enables onto one line.
    assign irq = (flags[0] & fin_ie) | (flags[1] & pause_ie);

    // R9: a read with no new event leaves both flags clear.
    p_rdclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !set_fin && !set_pause && !clear) |=> (flags == 2'b00));

    // R4: a finish flag persists until it is read or cleared.
    p_fin_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !rd && !clear) |=> flags[0]);
endmodule

// File: rtl/spi_pkt_seq.sv
// SPI packet sequencer: idle/run/paused control of one SPI master transfer.
// It frames length times repeat bytes, holds chip select in pause mode,
// and latches the finish and pause flags.
// Assumes: commands are single-cycle pulses, and byte_done comes from the
// shifter once per byte while shift_en is high.
module spi_pkt_seq
    import spi_seq_pkg::*;
#(
    parameter int LEN_W  = 10,
    parameter int LOOP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_act,
    input  logic              cmd_resume,
    input  logic              cmd_rst,
    input  logic              pause_en,
    input  logic              fin_ie,
    input  logic              pause_ie,
    input  logic [LEN_W-1:0]  pkt_len_m1,
    input  logic [LOOP_W-1:0] pkt_loop_m1,
    input  logic              byte_done,
    input  logic              status_rd,
    output logic              cs_active,
    output logic              shift_en,
    output logic              paused,
    output logic [LEN_W-1:0]  byte_idx,
    output logic [LOOP_W-1:0] loop_idx,
    output logic [1:0]        status,
    output logic              irq
);
    seq_state_e state_q, state_d;
    logic       last;
    logic       start_xfer;
    logic       done;
    logic       step;

    // Command and completion decode, with software reset suppressing all.
    always_comb begin
        start_xfer = !cmd_rst && (((state_q == SEQ_IDLE) && cmd_act) ||
                                  ((state_q == SEQ_PAUSE) && cmd_resume));
        step       = !cmd_rst && (state_q == SEQ_RUN) && byte_done;
        done       = step && last;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        if (cmd_rst) begin
            state_d = SEQ_IDLE;
        end else if (start_xfer) begin
            state_d = SEQ_RUN;
        end else if (done) begin
            state_d = pause_en ? SEQ_PAUSE : SEQ_IDLE;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    assign cs_active = (state_q != SEQ_IDLE);
    assign shift_en  = (state_q == SEQ_RUN);
    assign paused    = (state_q == SEQ_PAUSE);

    spi_seq_count #(
        .LEN_W  (LEN_W),
        .LOOP_W (LOOP_W)
    ) i_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cmd_rst),
        .start    (start_xfer),
        .step     (step),
        .len_m1   (pkt_len_m1),
        .loop_m1  (pkt_loop_m1),
        .byte_idx (byte_idx),
        .loop_idx (loop_idx),
        .last     (last)
    );

    spi_seq_flags i_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cmd_rst),
        .set_fin   (done && !pause_en),
        .set_pause (done && pause_en),
        .rd        (status_rd),
        .fin_ie    (fin_ie),
        .pause_ie  (pause_ie),
        .flags     (status),
        .irq       (irq)
    );

    // R2: activate in idle starts a transfer with zeroed counters.
    p_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_IDLE && cmd_act && !cmd_rst)
        |=> (shift_en && cs_active && byte_idx == '0 && loop_idx == '0));

    // R3: a byte that is not the final one keeps the transfer running.
    p_no_early_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_RUN && byte_done && !last && !cmd_rst) |=> shift_en);

    // R5: completion in pause mode holds chip select and raises the pause flag.
    p_pause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_RUN && byte_done && last && pause_en && !cmd_rst)
        |=> (paused && cs_active && status[1]));

    // R4: completion without pause mode releases chip select with a finish flag.
    p_finish_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_RUN && byte_done && last && !pause_en && !cmd_rst)
        |=> (!cs_active && status[0]));

    // R7: software reset always lands in a clean idle state.
    p_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rst |=> (!cs_active && status == 2'b00 && byte_idx == '0 && loop_idx == '0));
endmodule

// File: tb/test_spi_pkt_seq.sv
// Self-checking bench for the SPI packet sequencer: random transfers
// mixed with directed corner cases, checked against bench-side arithmetic.
module test_spi_pkt_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_act = 0, cmd_resume = 0, cmd_rst = 0;
    logic       pause_en = 0, fin_ie = 0, pause_ie = 0;
    logic [9:0] pkt_len_m1 = '0;
    logic [7:0] pkt_loop_m1 = '0;
    logic       byte_done = 0, status_rd = 0;
    logic       cs_active, shift_en, paused, irq;
    logic [9:0] byte_idx;
    logic [7:0] loop_idx;
    logic [1:0] status;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit in_pause = 0;

    always #4 clk = ~clk;

    spi_pkt_seq i_spi_pkt_seq (
        .clk(clk), .rst_n(rst_n), .cmd_act(cmd_act), .cmd_resume(cmd_resume),
        .cmd_rst(cmd_rst), .pause_en(pause_en), .fin_ie(fin_ie), .pause_ie(pause_ie),
        .pkt_len_m1(pkt_len_m1), .pkt_loop_m1(pkt_loop_m1), .byte_done(byte_done),
        .status_rd(status_rd), .cs_active(cs_active), .shift_en(shift_en),
        .paused(paused), .byte_idx(byte_idx), .loop_idx(loop_idx),
        .status(status), .irq(irq)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired act=%0d exp=0", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_byte(input int k, input int len_m1);
        return k % (len_m1 + 1);
    endfunction

    function automatic int exp_loop(input int k, input int len_m1);
        return k / (len_m1 + 1);
    endfunction

    function automatic int exp_irq(input int st, input int fe, input int pe);
        return ((st & 1) & fe) | (((st >> 1) & 1) & pe);
    endfunction

    // One clock: inputs set by caller are applied, results visible at return.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cmd_act = 0; cmd_resume = 0; cmd_rst = 0; byte_done = 0; status_rd = 0;
    endtask

    task automatic start_xfer(input int len, input int loop);
        pkt_len_m1 = len[9:0];
        pkt_loop_m1 = loop[7:0];
        if (in_pause) cmd_resume = 1; else cmd_act = 1;
        tick();
        check("R2 cs after start", cs_active, 1);
        check("R2 shift after start", shift_en, 1);
        check("R2 byte_idx after start", byte_idx, 0);
        check("R6 cs held / R2 loop_idx zero", loop_idx, 0);
    endtask

    // Runs a full transfer; optional read strobe on the final byte.
    task automatic run_bytes(input int len, input int loop, input int gapmax,
                             input bit rd_last, input bit detail);
        int total = (len + 1) * (loop + 1);
        for (int k = 1; k <= total; k++) begin
            int gap = (gapmax > 0) ? int'($urandom_range(gapmax, 0)) : 0;
            for (int g = 0; g < gap; g++) tick();
            byte_done = 1;
            if (k == total) status_rd = rd_last;
            tick();
            if (k < total && (detail || k == total - 1)) begin
                check("R3 byte_idx", byte_idx, exp_byte(k, len));
                check("R3 loop_idx", loop_idx, exp_loop(k, len));
                check("R3 still running", shift_en, 1);
            end
        end
    endtask

    task automatic check_done(input int len, input int loop, input bit pe);
        if (pe) begin
            check("R5 paused", paused, 1);
            check("R5 cs held", cs_active, 1);
            check("R5 shift off", shift_en, 0);
            check("R5 pause flag", status, 2);
        end else begin
            check("R4 cs released", cs_active, 0);
            check("R4 shift off", shift_en, 0);
            check("R4 finish flag", status, 1);
        end
        check("R10 final byte_idx", byte_idx, len);
        check("R10 final loop_idx", loop_idx, loop);
        check("R8 irq", irq, exp_irq(status, fin_ie, pause_ie));
        in_pause = pe;
    endtask

    initial begin
        void'($urandom(32'h5EC0_0042));
        @(negedge clk);
        tick(); tick();
        check("R1 cs", cs_active, 0);
        check("R1 shift", shift_en, 0);
        check("R1 paused", paused, 0);
        check("R1 status", status, 0);
        check("R1 irq", irq, 0);
        check("R1 byte_idx", byte_idx, 0);
        rst_n = 1;
        tick();

        // R6: resume in idle does nothing.
        cmd_resume = 1; tick();
        check("R6 resume ignored in idle", cs_active, 0);

        // R10: bytes in idle do nothing.
        byte_done = 1; tick();
        check("R10 idle byte ignored", byte_idx, 0);

        // Directed: capture at start, later field changes ignored (R2).
        fin_ie = 1; pause_ie = 1; pause_en = 0;
        start_xfer(2, 1);
        pkt_len_m1 = 10'd9; pkt_loop_m1 = 8'd5;
        run_bytes(2, 1, 0, 0, 1);
        check_done(2, 1, 0);

        // R9: read clears flag and irq.
        status_rd = 1; tick();
        check("R9 read clears status", status, 0);
        check("R9 irq cleared", irq, 0);

        // R6: activate while running is ignored.
        start_xfer(3, 0);
        byte_done = 1; tick();
        byte_done = 1; tick();
        cmd_act = 1; tick();
        check("R6 act ignored while running", byte_idx, 2);
        byte_done = 1; tick();
        byte_done = 1; tick();
        check_done(3, 0, 0);

        // Pause mode, bytes in pause ignored, then resume (R5, R6, R10).
        pause_en = 1; fin_ie = 0;
        status_rd = 1; tick();
        start_xfer(1, 2);
        run_bytes(1, 2, 1, 0, 1);
        check_done(1, 2, 1);
        byte_done = 1; tick();
        check("R10 paused byte ignored", byte_idx, 1);
        cmd_act = 1; tick();
        check("R6 act ignored while paused", paused, 1);
        pause_en = 0; pause_ie = 0;
        status_rd = 1; tick();
        check("R8 irq low with flags clear", irq, 0);
        start_xfer(0, 0);
        run_bytes(0, 0, 0, 1, 0);
        check("R9 set wins over read", status, 1);
        check("R8 irq off when fin_ie=0", irq, 0);
        in_pause = 0;

        // R7: reset with activate, mid-transfer.
        start_xfer(5, 1);
        byte_done = 1; tick();
        byte_done = 1; tick();
        cmd_rst = 1; cmd_act = 1; tick();
        check("R7 reset idle", cs_active, 0);
        check("R7 flags cleared", status, 0);
        check("R7 counter zero", byte_idx, 0);
        // R7: reset from paused.
        pause_en = 1;
        start_xfer(0, 1);
        run_bytes(0, 1, 0, 0, 0);
        check_done(0, 1, 1);
        cmd_rst = 1; cmd_resume = 1; tick();
        check("R7 reset releases paused cs", cs_active, 0);
        check("R7 reset clears paused", paused, 0);
        in_pause = 0; pause_en = 0;

        // Boundaries: maximum length and maximum repeat count (R3).
        fin_ie = 1;
        start_xfer(1023, 1);
        run_bytes(1023, 1, 0, 0, 0);
        check_done(1023, 1, 0);
        status_rd = 1; tick();
        start_xfer(0, 255);
        run_bytes(0, 255, 0, 0, 0);
        check_done(0, 255, 0);
        status_rd = 1; tick();

        // Random transfers.
        for (int t = 0; t < 30; t++) begin
            int len = int'($urandom_range(7, 0));
            int loop = int'($urandom_range(3, 0));
            bit pe = 1'($urandom_range(1, 0));
            fin_ie = 1'($urandom_range(1, 0));
            pause_ie = 1'($urandom_range(1, 0));
            start_xfer(len, loop);
            pkt_len_m1 = 10'($urandom_range(1023, 0));
            pause_en = pe;
            run_bytes(len, loop, 2, 0, 1);
            check_done(len, loop, pe);
            status_rd = 1; tick();
            check("R9 read clears random", status, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule